// File: doc/BRIEF.md
# Phase-Sliced Shared Video Memory Arbiter

This block lets one byte-wide static RAM serve both an 8-bit CPU and a video fetch engine. It gives each of them a fixed half of every CPU clock cycle, so neither side has to request access or wait for it. The block runs on the dot clock and divides it down to make the CPU's phase-2 clock. In the low half of phase 2 the RAM address comes from a video fetch counter, and the byte read there is registered for the display pipeline. In the high half the RAM address comes from the CPU.

The CPU's address, read/write flag and write data are captured on the last dot tick before phase 2 rises. They are therefore stable before that edge and for the whole CPU slot, whatever the CPU pins do afterwards. The device strobe for memory and I/O rises a programmable number of dot ticks after phase 2 rises and drops on the same tick as phase 2. A write is therefore only attempted once the address has settled. The write is committed by the rising edge of the active-low write enable at the end of the slot.

The video counter loads a start address when a frame-start pulse arrives. Otherwise it steps by one per video slot while fetching is enabled.

Top module: `vram_phase_arbiter`

## Requirements
- R1: With the default divide of 4, `cpu_phi2` repeats every 4 dot ticks. It is low for 2 ticks, then high for 2. The low half comes first after reset.
- R2: While `cpu_phi2` is low, `ram_addr` equals `vid_addr`. While it is high, `ram_addr` equals the captured CPU address.
- R3: The CPU address, `cpu_rnw` (1 = read, 0 = write) and write data are captured on the last dot tick of the low half. Changing these inputs during the high half has no effect on `ram_addr`, `ram_wdata` or `ram_we_n`.
- R4: `dev_strobe` rises the configured delay (default 1 tick) after `cpu_phi2` rises. It falls on the same tick as `cpu_phi2`, never before or after it.
- R5: `ram_we_n` is low only while `dev_strobe` is high in a captured write cycle. It is never low while `cpu_phi2` is low.
- R6: `ram_addr` and `ram_wdata` stay unchanged for the whole interval in which `ram_we_n` is low. The byte a CPU write stores is read back unchanged by the video port.
- R7: At the end of a read cycle, `cpu_rdata` takes the RAM byte at the captured address. After a write cycle, `cpu_rdata` keeps its previous value.
- R8: On the last tick of the low half, `vid_data` registers the byte read at the video address. `vid_valid` is then high for exactly one tick, and only if `vid_fetch_en` was high.
- R9: At the end of each video slot, `vid_addr` increments by one (wrapping at 15 bits) if `vid_fetch_en` is high, and holds if it is low. It never changes at any other tick.
- R10: A `vid_frame` pulse on any tick loads `vid_start` into `vid_addr` at the next video slot end. This load takes priority over the increment.
- R11: During and straight after reset, `cpu_phi2` is low, `ram_we_n` is high, `dev_strobe`, `vid_valid`, `vid_addr` and `cpu_rdata` are zero, and `ram_oe_n` is low.
- R12: `ram_oe_n` is low for the whole low half and while `dev_strobe` is high in a read cycle. It is high in the rest of the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_phi2 | output | 1 | Phase-2 clock to the CPU |
| cpu_addr | input | 15 | CPU address |
| cpu_rnw | input | 1 | CPU direction, 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| dev_strobe | output | 1 | Delayed-lead memory/I/O strobe |
| vid_start | input | 15 | Frame start address for the video counter |
| vid_frame | input | 1 | Frame start pulse |
| vid_fetch_en | input | 1 | Video fetch enable |
| vid_addr | output | 15 | Current video fetch address |
| vid_data | output | 8 | Fetched video byte |
| vid_valid | output | 1 | One-tick valid pulse for `vid_data` |
| ram_addr | output | 15 | Multiplexed RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |

## Verification
The bench moves the CPU pins to inverted values halfway through the CPU slot. A design that sampled them late would show the wrong address or write on the RAM. Each byte the CPU writes is fetched back through the video port in a later slot, so a write landing in the video slot, or at an unsettled address, shows up as corrupted display data.

A frame-start pulse is sent both inside and outside the video slot. A design that dropped the pulse, or let it change the address mid-slot, would fetch from the wrong place. The counter is also run across the 15-bit wrap, and run with fetching disabled, to catch stray increments.

// File: rtl/vr_pkg.sv
package vr_pkg;

   typedef enum logic {
      SLOT_VIDEO = 1'b0,
      SLOT_CPU   = 1'b1
   } slot_e;

   function automatic int unsigned half_of(input int unsigned div);
      return div / 2;
   endfunction

endpackage

// File: rtl/vr_phase_gen.sv
module vr_phase_gen
   import vr_pkg::*;
#(
   parameter int unsigned DIV = 4,
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [CW-1:0] ph_cnt,
   output slot_e         slot,
   output logic          lo_last,
   output logic          hi_last
);
   localparam int unsigned HALF = half_of(DIV);
   localparam logic [CW-1:0] LAST_TICK = CW'(DIV - 1);
   localparam logic [CW-1:0] LO_END    = CW'(HALF - 1);
   localparam logic [CW-1:0] HI_START  = CW'(HALF);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_cnt <= '0;
      end else if (ph_cnt == LAST_TICK) begin
         ph_cnt <= '0;
      end else begin
         ph_cnt <= ph_cnt + 1'b1;
      end
   end

   assign slot    = (ph_cnt >= HI_START) ? SLOT_CPU : SLOT_VIDEO;
   assign lo_last = (ph_cnt == LO_END);
   assign hi_last = (ph_cnt == LAST_TICK);

   AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
      lo_last |=> (slot == SLOT_CPU)); // R1
   AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
      hi_last |=> (slot == SLOT_VIDEO)); // R1

endmodule

// File: rtl/vr_strobe_gen.sv
module vr_strobe_gen
   import vr_pkg::*;
#(
   parameter int unsigned DIV = 4,
   parameter int unsigned DLY = 1,
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] ph_cnt,
   input  slot_e         slot,
   output logic          strobe
);
   localparam int unsigned HALF = half_of(DIV);
   localparam logic [CW-1:0] ON_AT = CW'(HALF + DLY);

   logic phi2;
   assign phi2 = (slot == SLOT_CPU);

   generate
      if (DLY == 0) begin : g_nodelay
         logic unused_cnt;
         assign unused_cnt = ^ph_cnt;
         assign strobe = phi2;
      end else begin : g_delay
         assign strobe = phi2 && (ph_cnt >= ON_AT);

         AST_STROBE_LEAD: assert property (@(posedge clk) disable iff (rst)
            $rose(phi2) |-> !strobe); // R4
      end
   endgenerate

   AST_STROBE_TRAIL: assert property (@(posedge clk) disable iff (rst)
      $fell(strobe) |-> $fell(phi2)); // R4
   AST_STROBE_INSLOT: assert property (@(posedge clk) disable iff (rst)
      strobe |-> phi2); // R4

endmodule

// File: rtl/vr_cpu_port.sv
module vr_cpu_port #(
   parameter int unsigned AW = 15,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cap_en,
   input  logic          rd_done,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_rnw,
   input  logic [DW-1:0] cpu_wdata,
   input  logic [DW-1:0] ram_rdata,
   output logic [AW-1:0] addr_q,
   output logic          rnw_q,
   output logic [DW-1:0] wdata_q,
   output logic [DW-1:0] rdata_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         rnw_q   <= 1'b1;
         wdata_q <= '0;
      end else if (cap_en) begin
         addr_q  <= cpu_addr;
         rnw_q   <= cpu_rnw;
         wdata_q <= cpu_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q <= '0;
      end else if (rd_done && rnw_q) begin
         rdata_q <= ram_rdata;
      end
   end

   AST_CPU_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(cap_en) |-> ($stable(addr_q) && $stable(rnw_q) && $stable(wdata_q))); // R3
   AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (rst)
      !$past(rd_done && rnw_q) |-> $stable(rdata_q)); // R7

endmodule

// File: rtl/vr_video_ctr.sv
module vr_video_ctr #(
   parameter int unsigned AW = 15,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          slot_end,
   input  logic          frame,
   input  logic          fetch_en,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] ram_rdata,
   output logic [AW-1:0] vaddr,
   output logic [DW-1:0] vdata,
   output logic          vvalid
);
   logic frame_pend;
   logic frame_now;

   assign frame_now = frame_pend || frame;

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_pend <= 1'b0;
      end else if (slot_end) begin
         frame_pend <= 1'b0;
      end else if (frame) begin
         frame_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vaddr <= '0;
      end else if (slot_end) begin
         if (frame_now) begin
            vaddr <= start_addr;
         end else if (fetch_en) begin
            vaddr <= vaddr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vdata  <= '0;
         vvalid <= 1'b0;
      end else begin
         vvalid <= slot_end && fetch_en;
         if (slot_end && fetch_en) begin
            vdata <= ram_rdata;
         end
      end
   end

   AST_VID_PULSE: assert property (@(posedge clk) disable iff (rst)
      vvalid |=> !vvalid); // R8
   AST_VID_HOLD: assert property (@(posedge clk) disable iff (rst)
      !slot_end |=> $stable(vaddr)); // R9
   AST_VID_LOAD: assert property (@(posedge clk) disable iff (rst)
      (slot_end && frame_now) |=> (vaddr == $past(start_addr))); // R10

endmodule

// File: rtl/vram_phase_arbiter.sv
module vram_phase_arbiter
   import vr_pkg::*;
#(
   parameter int unsigned AW        = 15,
   parameter int unsigned DW        = 8,
   parameter int unsigned DIV       = 4,
   parameter int unsigned STROBE_DLY = 1
) (
   input  logic          clk,
   input  logic          rst,
   output logic          cpu_phi2,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_rnw,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          dev_strobe,
   input  logic [AW-1:0] vid_start,
   input  logic          vid_frame,
   input  logic          vid_fetch_en,
   output logic [AW-1:0] vid_addr,
   output logic [DW-1:0] vid_data,
   output logic          vid_valid,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   input  logic [DW-1:0] ram_rdata,
   output logic          ram_we_n,
   output logic          ram_oe_n
);
   localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int unsigned HALF = half_of(DIV);

   generate
      if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
         $error("DIV must be even and at least 4");
      end
      if (STROBE_DLY >= HALF) begin : g_bad_dly
         $error("STROBE_DLY must be below half of DIV");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("AW and DW must be positive");
      end
   endgenerate

   logic [CW-1:0] ph_cnt;
   slot_e         slot;
   logic          lo_last;
   logic          hi_last;
   logic          strobe;
   logic [AW-1:0] cpu_addr_q;
   logic          cpu_rnw_q;
   logic [DW-1:0] cpu_wdata_q;

   vr_phase_gen #(.DIV(DIV)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .ph_cnt  (ph_cnt),
      .slot    (slot),
      .lo_last (lo_last),
      .hi_last (hi_last)
   );

   vr_strobe_gen #(.DIV(DIV), .DLY(STROBE_DLY)) u_strobe (
      .clk    (clk),
      .rst    (rst),
      .ph_cnt (ph_cnt),
      .slot   (slot),
      .strobe (strobe)
   );

   vr_cpu_port #(.AW(AW), .DW(DW)) u_cpu (
      .clk       (clk),
      .rst       (rst),
      .cap_en    (lo_last),
      .rd_done   (hi_last),
      .cpu_addr  (cpu_addr),
      .cpu_rnw   (cpu_rnw),
      .cpu_wdata (cpu_wdata),
      .ram_rdata (ram_rdata),
      .addr_q    (cpu_addr_q),
      .rnw_q     (cpu_rnw_q),
      .wdata_q   (cpu_wdata_q),
      .rdata_q   (cpu_rdata)
   );

   vr_video_ctr #(.AW(AW), .DW(DW)) u_video (
      .clk        (clk),
      .rst        (rst),
      .slot_end   (lo_last),
      .frame      (vid_frame),
      .fetch_en   (vid_fetch_en),
      .start_addr (vid_start),
      .ram_rdata  (ram_rdata),
      .vaddr      (vid_addr),
      .vdata      (vid_data),
      .vvalid     (vid_valid)
   );

   assign cpu_phi2   = (slot == SLOT_CPU);
   assign dev_strobe = strobe;
   assign ram_addr   = (slot == SLOT_CPU) ? cpu_addr_q : vid_addr;
   assign ram_wdata  = cpu_wdata_q;
   assign ram_we_n   = !(strobe && !cpu_rnw_q);
   assign ram_oe_n   = !((slot == SLOT_VIDEO) || (strobe && cpu_rnw_q));

   AST_NO_VIDEO_WRITE: assert property (@(posedge clk) disable iff (rst)
      !cpu_phi2 |-> ram_we_n); // R5
   AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      !ram_we_n |-> dev_strobe); // R5
   AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
      (!ram_we_n && $past(!ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_wdata))); // R6
   AST_NO_DRIVE_CLASH: assert property (@(posedge clk) disable iff (rst)
      !(ram_we_n == 1'b0 && ram_oe_n == 1'b0)); // R12

endmodule

// File: tb/vram_phase_arbiter_bench.sv
`timescale 1ns/1ps
module vram_phase_arbiter_bench;
   localparam int AW = 15;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          cpu_phi2;
   logic [AW-1:0] cpu_addr;
   logic          cpu_rnw;
   logic [DW-1:0] cpu_wdata;
   logic [DW-1:0] cpu_rdata;
   logic          dev_strobe;
   logic [AW-1:0] vid_start;
   logic          vid_frame;
   logic          vid_fetch_en;
   logic [AW-1:0] vid_addr;
   logic [DW-1:0] vid_data;
   logic          vid_valid;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata;
   logic          ram_we_n;
   logic          ram_oe_n;

   always #2 clk = ~clk;

   vram_phase_arbiter u_vram_phase_arbiter (
      .clk(clk), .rst(rst), .cpu_phi2(cpu_phi2), .cpu_addr(cpu_addr),
      .cpu_rnw(cpu_rnw), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .dev_strobe(dev_strobe), .vid_start(vid_start), .vid_frame(vid_frame),
      .vid_fetch_en(vid_fetch_en), .vid_addr(vid_addr), .vid_data(vid_data),
      .vid_valid(vid_valid), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
   );

   // small RAM model, aliased on the low 9 address bits
   logic [DW-1:0] mem [512];
   assign ram_rdata = mem[ram_addr[8:0]];
   always @(posedge clk) if (!ram_we_n) mem[ram_addr[8:0]] <= ram_wdata;

   logic [DW-1:0] exp_mem [512];
   logic [AW-1:0] m_vid;
   logic [DW-1:0] m_rdata;
   logic          m_pend;
   int            n_run  = 0;
   int            n_fail = 0;
   bit            done   = 1'b0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // vector: addr, rnw, wdata, fetch, frame (0 none, 1 in video slot, 2 in CPU slot)
   typedef struct packed {
      logic [14:0] addr;
      logic        rnw;
      logic [7:0]  wdata;
      logic        fetch;
      logic [1:0]  frame;
   } vec_t;

   localparam vec_t VECS [13] = '{
      '{15'h010, 1'b0, 8'hA5, 1'b0, 2'd0},
      '{15'h011, 1'b0, 8'h3C, 1'b0, 2'd0},
      '{15'h012, 1'b0, 8'hF0, 1'b0, 2'd0},
      '{15'h013, 1'b0, 8'h0F, 1'b0, 2'd1},
      '{15'h1FF, 1'b1, 8'h00, 1'b1, 2'd0},
      '{15'h011, 1'b1, 8'h00, 1'b1, 2'd0},
      '{15'h014, 1'b0, 8'h77, 1'b1, 2'd0},
      '{15'h014, 1'b1, 8'h00, 1'b1, 2'd0},
      '{15'h020, 1'b0, 8'h99, 1'b0, 2'd0},
      '{15'h020, 1'b1, 8'h00, 1'b1, 2'd2},
      '{15'h000, 1'b1, 8'h00, 1'b1, 2'd0},
      '{15'h011, 1'b0, 8'h55, 1'b1, 2'd0},
      '{15'h011, 1'b1, 8'h00, 1'b1, 2'd0}
   };

   // entered at the negedge of the first video tick; returns at the next one
   task automatic run_cycle(input vec_t v);
      logic [AW-1:0] old_vid;
      cpu_addr     = v.addr;
      cpu_rnw      = v.rnw;
      cpu_wdata    = v.wdata;
      vid_fetch_en = v.fetch;
      vid_frame    = (v.frame == 2'd1);
      if (v.frame == 2'd1) m_pend = 1'b1;
      chk("R1", "phi2 tick0", cpu_phi2, 1'b0);
      chk("R2", "video addr tick0", ram_addr, m_vid);
      chk("R12", "oe in video slot", ram_oe_n, 1'b0);
      @(negedge clk);
      vid_frame = 1'b0;
      chk("R1", "phi2 tick1", cpu_phi2, 1'b0);
      chk("R5", "no write in video slot", ram_we_n, 1'b1);
      chk("R9", "video addr held in slot", vid_addr, m_vid);
      @(negedge clk);
      old_vid = m_vid;
      if (m_pend) m_vid = vid_start;
      else if (v.fetch) m_vid = m_vid + 1'b1;
      m_pend = 1'b0;
      chk("R1", "phi2 tick2", cpu_phi2, 1'b1);
      chk("R4", "strobe delayed", dev_strobe, 1'b0);
      chk("R2", "cpu addr in cpu slot", ram_addr, v.addr);
      chk("R8", "video valid", vid_valid, v.fetch);
      if (v.fetch) chk("R6", "video readback", vid_data, exp_mem[old_vid[8:0]]);
      chk("R10", "video addr after slot", vid_addr, m_vid);
      // disturb the CPU pins during the CPU slot
      cpu_addr  = ~v.addr;
      cpu_rnw   = ~v.rnw;
      cpu_wdata = ~v.wdata;
      vid_frame = (v.frame == 2'd2);
      if (v.frame == 2'd2) m_pend = 1'b1;
      @(negedge clk);
      vid_frame = 1'b0;
      chk("R4", "strobe on", dev_strobe, 1'b1);
      chk("R3", "captured addr", ram_addr, v.addr);
      chk("R5", "write enable", ram_we_n, v.rnw);
      if (!v.rnw) chk("R3", "captured wdata", ram_wdata, v.wdata);
      chk("R12", "oe in cpu slot", ram_oe_n, !v.rnw);
      chk("R8", "valid one tick", vid_valid, 1'b0);
      @(negedge clk);
      if (!v.rnw) exp_mem[v.addr[8:0]] = v.wdata;
      else m_rdata = exp_mem[v.addr[8:0]];
      chk("R4", "strobe falls with phi2", dev_strobe, 1'b0);
      chk("R7", "cpu rdata", cpu_rdata, m_rdata);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 512; i++) begin
         mem[i]     = '0;
         exp_mem[i] = '0;
      end
      rst = 1'b1; cpu_addr = '0; cpu_rnw = 1'b1; cpu_wdata = '0;
      vid_start = 15'h010; vid_frame = 1'b0; vid_fetch_en = 1'b0;
      m_vid = '0; m_rdata = '0; m_pend = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11", "reset phi2", cpu_phi2, 1'b0);
      chk("R11", "reset we_n", ram_we_n, 1'b1);
      chk("R11", "reset oe_n", ram_oe_n, 1'b0);
      chk("R11", "reset strobe", dev_strobe, 1'b0);
      chk("R11", "reset valid", vid_valid, 1'b0);
      chk("R11", "reset vid addr", vid_addr, 15'h0);
      chk("R11", "reset rdata", cpu_rdata, 8'h0);
      rst = 1'b0;
      for (int i = 0; i < 13; i++) run_cycle(VECS[i]);
      // wrap of the fetch counter at 15 bits
      vid_start = 15'h7FFE;
      run_cycle('{15'h030, 1'b1, 8'h00, 1'b0, 2'd1});
      run_cycle('{15'h031, 1'b1, 8'h00, 1'b1, 2'd0});
      run_cycle('{15'h032, 1'b1, 8'h00, 1'b1, 2'd0});
      chk("R9", "wrap to zero", vid_addr, 15'h0000);
      // fetch off: counter holds and no valid pulse
      run_cycle('{15'h033, 1'b0, 8'hC3, 1'b0, 2'd0});
      run_cycle('{15'h033, 1'b1, 8'h00, 1'b0, 2'd0});
      chk("R9", "hold with fetch off", vid_addr, 15'h0000);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule